// File: doc/BRIEF.md
# DMA Transfer Unit Size Selector

This block picks the widest transfer unit that a DMA request can legally use. A request gives a start address, a byte length, the width of the peripheral port in bytes and the largest burst the port accepts. The unit must meet three limits. The address must be aligned to it. The length must be a whole number of units. The unit must not exceed the port width times the maximum burst. The block ORs the three quantities together and takes the position of the lowest set bit as the log2 of the unit. It then applies the hardware's limits to that value.

The result has three parts: a 3-bit unit size code for the channel command word, the log2 shift, and the number of units to move. An error flag is raised when that number does not fit the 24-bit count field. A strobe on the input loads a new request. The results appear one clock later, together with a single-cycle valid pulse, and they hold until the next strobe.

Top module: `xfer_unit_sel`

## Requirements
- R1: The order is the index of the lowest set bit of (reqAddr OR reqLen OR portWidth×maxBurst), subject to R2 to R4, and it is reported on unitShift.
- R2: An order of 3 (8-byte units) is not supported and is reported as order 2.
- R3: An order above parameter MAX_ORD (5, 6 or 7; default 7) is reported as MAX_ORD.
- R4: When the OR-combined value is zero, the order is MAX_ORD.
- R5: sizeCode encodes the order as follows: 1 byte→1, 2 bytes→2, 4 bytes→0, 16 bytes→3, 32 bytes→4, 64 bytes→5, 128 bytes→6. The code 7 never appears.
- R6: unitCount equals the low 24 bits of reqLen shifted right by the order.
- R7: countErr is 1 exactly when reqLen shifted right by the order exceeds 2^24−1.
- R8: outValid is a one-cycle pulse on the clock edge after each cycle with inValid high. The outputs change only at such edges and hold their values otherwise.
- R9: While rstN is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Start address in bytes |
| reqLen | input | 32 | Length in bytes |
| portWidth | input | 3 | Port width in bytes (1, 2 or 4) |
| maxBurst | input | 8 | Maximum burst length in beats |
| outValid | output | 1 | Result pulse |
| sizeCode | output | 3 | Unit size code |
| unitShift | output | 3 | log2 of unit size in bytes |
| unitCount | output | 24 | Length in units |
| countErr | output | 1 | Unit count overflows 24 bits |

## Verification
Directed requests are built so that each of the three inputs, in turn, is the one that limits the order. This shows that none of them is left out of the OR. Four further directed cases hit the special orders: an exact 8-byte result, a result above the cap, an all-zero request and an odd address. These separate the demotion path, the clamp path and the zero path from the plain bit search. Length cases at 2^24−1, at 2^24 with a shift that brings the count back under the limit, and at 2^25 find errors in the overflow boundary. Random requests are given a random number of trailing zeros, so that every order from 0 to beyond the cap occurs. The bench also checks that stimulus applied without a strobe leaves every output unchanged.

// File: rtl/xfer_unit_sel_pkg.sv
package xfer_unit_sel_pkg;

  localparam int SHIFT_W = 3;
  localparam int CODE_W  = 3;

  typedef struct packed {
    logic capture;
    logic pulse;
  } sel_strobe_t;

  // Hardware size code for a unit of 2**ord bytes; order 3 never reaches here.
  function automatic logic [CODE_W-1:0] codeForOrder(input logic [SHIFT_W-1:0] ord);
    logic [CODE_W-1:0] code;
    case (ord)
      3'd0:    code = 3'd1;
      3'd1:    code = 3'd2;
      3'd2:    code = 3'd0;
      3'd4:    code = 3'd3;
      3'd5:    code = 3'd4;
      3'd6:    code = 3'd5;
      default: code = 3'd6;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/xfer_unit_sel_lsb.sv
module xfer_unit_sel_lsb #(
  parameter int VEC_W = 32,
  parameter int IDX_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);

  logic [VEC_W:0]   lowerSeen;
  logic [VEC_W-1:0] oneHot;

  assign lowerSeen[0] = 1'b0;

  for (genvar i = 0; i < VEC_W; i++) begin : g_chain
    assign oneHot[i]      = vec[i] & ~lowerSeen[i];
    assign lowerSeen[i+1] = lowerSeen[i] | vec[i];
  end

  assign found = lowerSeen[VEC_W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (oneHot[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/xfer_unit_sel_ctrl.sv
module xfer_unit_sel_ctrl
  import xfer_unit_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output sel_strobe_t strobes,
  output logic        outValid
);

  logic validQ;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign strobes.capture = inValid & rstN;
  assign strobes.pulse   = validQ;
  assign outValid        = strobes.pulse;

endmodule

// File: rtl/xfer_unit_sel_dp.sv
module xfer_unit_sel_dp
  import xfer_unit_sel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 32,
  parameter int WIDTH_W = 3,
  parameter int BURST_W = 8,
  parameter int COUNT_W = 24,
  parameter int MAX_ORD = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  sel_strobe_t        strobes,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [WIDTH_W-1:0] portWidth,
  input  logic [BURST_W-1:0] maxBurst,
  output logic [CODE_W-1:0]  sizeCode,
  output logic [SHIFT_W-1:0] unitShift,
  output logic [COUNT_W-1:0] unitCount,
  output logic               countErr
);

  localparam int PROD_W  = WIDTH_W + BURST_W;
  localparam int AL_W    = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;
  localparam int COMB_W  = (AL_W > PROD_W) ? AL_W : PROD_W;
  localparam int IDX_W   = $clog2(COMB_W);

  logic [PROD_W-1:0]  burstBytes;
  logic [COMB_W-1:0]  combined;
  logic [IDX_W-1:0]   lowIdx;
  logic               anySet;
  logic [SHIFT_W-1:0] ord;
  logic [LEN_W-1:0]   fullCount;
  logic               overflow;

  assign burstBytes = PROD_W'(portWidth) * PROD_W'(maxBurst);
  assign combined   = COMB_W'(reqAddr) | COMB_W'(reqLen) | COMB_W'(burstBytes);

  xfer_unit_sel_lsb #(.VEC_W(COMB_W), .IDX_W(IDX_W)) u_lsb (
    .vec   (combined),
    .idx   (lowIdx),
    .found (anySet)
  );

  always_comb begin
    if (!anySet)                       ord = SHIFT_W'(MAX_ORD);
    else if (lowIdx == IDX_W'(3))      ord = 3'd2;
    else if (lowIdx > IDX_W'(MAX_ORD)) ord = SHIFT_W'(MAX_ORD);
    else                               ord = lowIdx[SHIFT_W-1:0];
  end

  assign fullCount = reqLen >> ord;

  if (LEN_W > COUNT_W) begin : g_ovf
    assign overflow = |fullCount[LEN_W-1:COUNT_W];
  end else begin : g_noovf
    assign overflow = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeCode  <= '0;
      unitShift <= '0;
      unitCount <= '0;
      countErr  <= 1'b0;
    end else if (strobes.capture) begin
      sizeCode  <= codeForOrder(ord);
      unitShift <= ord;
      unitCount <= COUNT_W'(fullCount);
      countErr  <= overflow;
    end
  end

endmodule

// File: rtl/xfer_unit_sel.sv
module xfer_unit_sel
  import xfer_unit_sel_pkg::*;
#(
  parameter int MAX_ORD = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqLen,
  input  logic [2:0]  portWidth,
  input  logic [7:0]  maxBurst,
  output logic        outValid,
  output logic [2:0]  sizeCode,
  output logic [2:0]  unitShift,
  output logic [23:0] unitCount,
  output logic        countErr
);

  sel_strobe_t strobes;

  xfer_unit_sel_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  xfer_unit_sel_dp #(
    .ADDR_W (32), .LEN_W (32), .WIDTH_W (3), .BURST_W (8),
    .COUNT_W (24), .MAX_ORD (MAX_ORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .portWidth (portWidth),
    .maxBurst  (maxBurst),
    .sizeCode  (sizeCode),
    .unitShift (unitShift),
    .unitCount (unitCount),
    .countErr  (countErr)
  );

endmodule

// File: rtl/xfer_unit_sel_chk.sv
module xfer_unit_sel_chk #(
  parameter int MAX_ORD = 7
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        outValid,
  input logic [2:0]  sizeCode,
  input logic [2:0]  unitShift,
  input logic [23:0] unitCount,
  input logic        countErr
);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R8
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(sizeCode) && $stable(unitShift)
                   && $stable(unitCount) && $stable(countErr)));

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    sizeCode != 3'd7);

  // R2
  no_eight_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> unitShift != 3'd3);

  // R3
  order_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> unitShift <= 3'(MAX_ORD));

  // R5
  word_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && unitShift == 3'd2) |-> sizeCode == 3'd0);

endmodule

bind xfer_unit_sel xfer_unit_sel_chk #(.MAX_ORD(MAX_ORD)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .outValid  (outValid),
  .sizeCode  (sizeCode),
  .unitShift (unitShift),
  .unitCount (unitCount),
  .countErr  (countErr)
);

// File: tb/xfer_unit_sel_bench.sv
`timescale 1ns/1ps
module xfer_unit_sel_bench;

  localparam int MAX_ORD = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqLen = '0;
  logic [2:0]  portWidth = '0;
  logic [7:0]  maxBurst = '0;
  logic        outValid;
  logic [2:0]  sizeCode;
  logic [2:0]  unitShift;
  logic [23:0] unitCount;
  logic        countErr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_unit_sel #(.MAX_ORD(MAX_ORD)) u_xfer_unit_sel (
    .clk, .rstN, .inValid, .reqAddr, .reqLen, .portWidth, .maxBurst,
    .outValid, .sizeCode, .unitShift, .unitCount, .countErr
  );

  function automatic int expOrder(input logic [31:0] a, input logic [31:0] l,
                                  input int w, input int b);
    logic [31:0] c;
    int o;
    c = a | l | 32'(w * b);
    if (c == 0) return MAX_ORD;
    o = 0;
    while (!c[o]) o++;
    if (o == 3) return 2;
    if (o > MAX_ORD) return MAX_ORD;
    return o;
  endfunction

  function automatic int expCode(input int o);
    case (o)
      0: return 1;
      1: return 2;
      2: return 0;
      4: return 3;
      5: return 4;
      6: return 5;
      default: return 6;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] l,
                       input int w, input int b, input string req);
    int o;
    longint full;
    @(negedge clk);
    reqAddr = a; reqLen = l; portWidth = 3'(w); maxBurst = 8'(b);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    o = expOrder(a, l, w, b);
    full = longint'(l) >> o;
    check(req, "outValid R8", outValid, 1);
    check(req, "unitShift R1", unitShift, o);
    check(req, "sizeCode R5", sizeCode, expCode(o));
    check(req, "unitCount R6", unitCount, full & 64'hFFFFFF);
    check(req, "countErr R7", countErr, full > 64'hFFFFFF);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "outValid", outValid, 0);
    check("R9", "sizeCode", sizeCode, 0);
    check("R9", "unitShift", unitShift, 0);
    check("R9", "unitCount", unitCount, 0);
    check("R9", "countErr", countErr, 0);
    rstN = 1'b1;

    // R1 each input limiting in turn
    apply(32'h100, 32'h1000, 4, 16, "R1 burst");
    apply(32'h20, 32'h1000, 4, 64, "R1 addr");
    apply(32'h1000, 32'h50, 4, 64, "R1 len");
    // R2 exact 8-byte order demoted
    apply(32'h8, 32'h80, 4, 2, "R2");
    // R3 above cap
    apply(32'h1000, 32'h1000, 4, 64, "R3");
    // R4 all zero
    apply(32'h0, 32'h0, 0, 0, "R4");
    // R5 odd address gives byte units
    apply(32'h1, 32'h40, 4, 8, "R5");
    apply(32'h2, 32'h40, 2, 1, "R5 half");
    // R7 boundaries
    apply(32'h1, 32'hFFFFFF, 4, 8, "R7 max");
    apply(32'h2, 32'h1000000, 2, 1, "R7 shifted");
    apply(32'h1, 32'h2000000, 1, 1, "R7 over");
    apply(32'h4, 32'h4000000, 4, 1, "R7 over4");

    // R8 stimulus without strobe leaves outputs unchanged
    begin
      logic [2:0] c0, s0; logic [23:0] n0; logic e0;
      c0 = sizeCode; s0 = unitShift; n0 = unitCount; e0 = countErr;
      @(negedge clk);
      reqAddr = 32'h40; reqLen = 32'h800; portWidth = 3'd4; maxBurst = 8'd32;
      repeat (2) @(negedge clk);
      check("R8", "no pulse", outValid, 0);
      check("R8", "code held", sizeCode, c0);
      check("R8", "shift held", unitShift, s0);
      check("R8", "count held", unitCount, n0);
      check("R8", "err held", countErr, e0);
    end

    // random requests with varied trailing zeros
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, l;
      int w, b, sel;
      a = $urandom << ($urandom % 10);
      l = ($urandom >> ($urandom % 24)) << ($urandom % 10);
      sel = $urandom % 3;
      w = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
      b = ($urandom % 8 == 0) ? 0 : (1 << ($urandom % 8));
      if ($urandom % 5 == 0) b = $urandom % 256;
      apply(a, l, w, b, "R1 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule